// File: doc/BRIEF.md
# Power-Mode Controller With Clock Divider

This block keeps track of the operating mode of a small processor subsystem and produces the clock enables for its bus masters and its peripherals. It has five modes: a reset state, high-speed (full-rate bus-master clock), medium-speed (bus-master clock divided by a power of two), sleep and software standby. A 3-bit divider-select field chooses the bus-master rate. A new value in that field takes effect only on a cycle that marks the end of a bus cycle, so an access that is in progress never runs at two rates. The peripheral clock enable stays at full rate while the bus masters are slowed down.

A SLEEP strobe moves the block into sleep or software standby. Which of the two it enters depends on the standby-enable bit, the low-speed-on bit and the watchdog prescaler-select bit taken together. Any interrupt ends sleep. Only an external interrupt ends standby. On wake-up the block goes back to the rate that was in force before the SLEEP. An external reset or a watchdog overflow forces the reset state from any mode, and that wins over every other transition.

In medium-speed mode the divided clock is a one-cycle enable pulse taken from a free-running counter. The counter restarts whenever the mode or the applied divider changes, so the first divided period after a change is always a full one. Each bus-master state therefore lasts 2^n system clocks.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst`, `ext_rst_i` or `wdt_ovf_i` is high, the mode code is 0 (reset) and both clock enables are low. On the first clock after these inputs are all low, the block enters high-speed mode (code 1) with the applied divider cleared to 000.
- R2: The divider-select field is sampled only on a clock where `bus_end_i` is high in high-speed or medium-speed mode and no sleep or standby entry is taken on that clock. A change of the field on any other clock leaves the mode and the enable pattern unchanged.
- R3: In medium-speed mode (code 2) the applied select n, for n from 1 to 5, gives a `bm_clk_en_o` that is high for exactly one clock in every 2^n clocks. Selects 6 and 7 both give 32. `per_clk_en_o` stays high in this mode.
- R4: In high-speed mode (code 1) both enables are high on every clock. Applying a select of 000 at a bus-cycle end returns the block from medium-speed to high-speed mode.
- R5: A SLEEP strobe taken with standby-enable 0 and low-speed-on 0 enters sleep (code 3). In sleep `bm_clk_en_o` is low and `per_clk_en_o` is high. Either interrupt input ends sleep.
- R6: A SLEEP strobe taken with standby-enable 1, low-speed-on 0 and prescaler-select 0 enters software standby (code 4), with both enables low. `irq_int_i` alone has no effect in standby; only `irq_ext_i` ends it.
- R7: On waking from sleep or standby, the block returns to medium-speed mode if the applied divider is nonzero and to high-speed mode otherwise. The first bus-master pulse after waking comes a full divided period later.
- R8: `ext_rst_i` or `wdt_ovf_i` moves the block to the reset state on the next clock from any mode. This overrides a simultaneous bus-cycle end, SLEEP strobe or interrupt.
- R9: A SLEEP strobe with low-speed-on 1, or with standby-enable 1 and prescaler-select 1, leaves the mode unchanged.
- R10: When the applied divider or the mode changes, the divided-clock counter restarts. After the change `bm_clk_en_o` first pulses on the 2^n-th clock, so no divided period is ever shortened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel_i | input | 3 | Requested bus-master divider select (0 = full rate, n = divide by 2^n) |
| stby_en_i | input | 1 | Standby-enable control bit |
| lson_i | input | 1 | Low-speed-on control bit |
| wdt_pss_i | input | 1 | Watchdog prescaler-select bit |
| sleep_i | input | 1 | One-clock SLEEP instruction strobe |
| bus_end_i | input | 1 | One-clock strobe marking the end of the current bus cycle |
| irq_int_i | input | 1 | Internal interrupt request |
| irq_ext_i | input | 1 | External interrupt request |
| ext_rst_i | input | 1 | External reset request |
| wdt_ovf_i | input | 1 | Watchdog overflow |
| bm_clk_en_o | output | 1 | Bus-master clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| mode_o | output | 3 | Current mode: 0 reset, 1 high, 2 medium, 3 sleep, 4 standby |

## Verification
The divider is driven through a stepwise sequence (1, 2, 5, 7, back to 0). The select changes are first held off the bus-cycle-end strobe and then applied on it, which separates a design that samples the field at any time from one that waits for the boundary. Switching between divisions mid-period shows whether the counter restarts or carries a stale phase into a shortened first period. SLEEP is issued under every combination of the three control bits that matters, and both interrupt kinds are tried in each low-power mode, which tells the sleep wake rule apart from the standby one. Reset and watchdog requests are raised together with bus-end, SLEEP and interrupt strobes to expose any priority that is wrong.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    PM_RESET   = 3'd0,
    PM_HIGH    = 3'd1,
    PM_MEDIUM  = 3'd2,
    PM_SLEEP   = 3'd3,
    PM_STANDBY = 3'd4
  } pm_mode_e;
endpackage

// File: rtl/pmc_sleep_decode.sv
module pmc_sleep_decode (
  input  logic sleep_i,
  input  logic stby_en_i,
  input  logic lson_i,
  input  logic wdt_pss_i,
  output logic go_sleep_o,
  output logic go_stby_o
);
  // The three control bits together pick the low-power target
  always_comb begin
    go_sleep_o = sleep_i && !lson_i && !stby_en_i;
    go_stby_o  = sleep_i && !lson_i &&  stby_en_i && !wdt_pss_i;
  end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hard_rst_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             bus_end_i,
  input  logic             go_sleep_i,
  input  logic             go_stby_i,
  input  logic             irq_int_i,
  input  logic             irq_ext_i,
  output pm_mode_e         mode_d_o,
  output pm_mode_e         mode_q_o,
  output logic [SEL_W-1:0] div_d_o,
  output logic [SEL_W-1:0] div_q_o
);
  pm_mode_e         mode_q;
  logic [SEL_W-1:0] div_q;
  pm_mode_e         mode_d;
  logic [SEL_W-1:0] div_d;
  pm_mode_e         run_mode;

  // Mode to resume after a wake-up, decided by the divider already applied
  always_comb run_mode = (div_q != '0) ? PM_MEDIUM : PM_HIGH;

  always_comb begin
    mode_d = mode_q;
    div_d  = div_q;
    if (hard_rst_i) begin
      mode_d = PM_RESET;
      div_d  = '0;
    end else begin
      unique case (mode_q)
        PM_RESET: begin
          mode_d = PM_HIGH;
          div_d  = '0;
        end
        PM_HIGH, PM_MEDIUM: begin
          if (go_sleep_i) begin
            mode_d = PM_SLEEP;
          end else if (go_stby_i) begin
            mode_d = PM_STANDBY;
          end else if (bus_end_i) begin
            div_d  = div_sel_i;
            mode_d = (div_sel_i != '0) ? PM_MEDIUM : PM_HIGH;
          end
        end
        PM_SLEEP: begin
          if (irq_int_i || irq_ext_i) mode_d = run_mode;
        end
        PM_STANDBY: begin
          if (irq_ext_i) mode_d = run_mode;
        end
        default: begin
          mode_d = PM_RESET;
          div_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PM_RESET;
      div_q  <= '0;
    end else begin
      mode_q <= mode_d;
      div_q  <= div_d;
    end
  end

  assign mode_d_o = mode_d;
  assign mode_q_o = mode_q;
  assign div_d_o  = div_d;
  assign div_q_o  = div_q;
endmodule

// File: rtl/pmc_clk_div.sv
module pmc_clk_div
  import pmc_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  pm_mode_e         mode_d_i,
  input  pm_mode_e         mode_q_i,
  input  logic [SEL_W-1:0] div_d_i,
  input  logic [SEL_W-1:0] div_q_i,
  output logic             bm_en_o,
  output logic             per_en_o
);
  localparam int CNT_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] lim;
  logic             restart;
  logic             bm_q;
  logic             per_q;
  int unsigned      shift;

  // Larger selects saturate at the widest division
  always_comb begin
    shift = (int'(div_d_i) > MAX_SHIFT) ? MAX_SHIFT : int'(div_d_i);
    lim   = CNT_W'((32'd1 << shift) - 32'd1);
  end

  always_comb begin
    restart = (mode_d_i != mode_q_i) || (div_d_i != div_q_i);
    if (restart)
      cnt_d = '0;
    else if (cnt_q >= lim)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      bm_q  <= 1'b0;
      per_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bm_q  <= (mode_d_i == PM_HIGH) ||
               ((mode_d_i == PM_MEDIUM) && (cnt_d == lim));
      per_q <= (mode_d_i == PM_HIGH) || (mode_d_i == PM_MEDIUM) ||
               (mode_d_i == PM_SLEEP);
    end
  end

  assign bm_en_o  = bm_q;
  assign per_en_o = per_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int MAX_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             stby_en_i,
  input  logic             lson_i,
  input  logic             wdt_pss_i,
  input  logic             sleep_i,
  input  logic             bus_end_i,
  input  logic             irq_int_i,
  input  logic             irq_ext_i,
  input  logic             ext_rst_i,
  input  logic             wdt_ovf_i,
  output logic             bm_clk_en_o,
  output logic             per_clk_en_o,
  output logic [2:0]       mode_o
);
  logic             go_sleep;
  logic             go_stby;
  logic             hard_rst;
  pm_mode_e         mode_d;
  pm_mode_e         mode_q;
  logic [SEL_W-1:0] div_d;
  logic [SEL_W-1:0] div_q;

  assign hard_rst = ext_rst_i || wdt_ovf_i;

  pmc_sleep_decode u_dec (
    .sleep_i    (sleep_i),
    .stby_en_i  (stby_en_i),
    .lson_i     (lson_i),
    .wdt_pss_i  (wdt_pss_i),
    .go_sleep_o (go_sleep),
    .go_stby_o  (go_stby)
  );

  pmc_mode_fsm #(.SEL_W(SEL_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .hard_rst_i (hard_rst),
    .div_sel_i  (div_sel_i),
    .bus_end_i  (bus_end_i),
    .go_sleep_i (go_sleep),
    .go_stby_i  (go_stby),
    .irq_int_i  (irq_int_i),
    .irq_ext_i  (irq_ext_i),
    .mode_d_o   (mode_d),
    .mode_q_o   (mode_q),
    .div_d_o    (div_d),
    .div_q_o    (div_q)
  );

  pmc_clk_div #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_div (
    .clk      (clk),
    .rst      (rst),
    .mode_d_i (mode_d),
    .mode_q_i (mode_q),
    .div_d_i  (div_d),
    .div_q_i  (div_q),
    .bm_en_o  (bm_clk_en_o),
    .per_en_o (per_clk_en_o)
  );

  assign mode_o = mode_q;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rst,
  input logic       sleep_i,
  input logic       bus_end_i,
  input logic       irq_ext_i,
  input logic       ext_rst_i,
  input logic       wdt_ovf_i,
  input logic       bm_clk_en_o,
  input logic       per_clk_en_o,
  input logic [2:0] mode_o
);
  AST_RESET_FORCE: assert property (@(posedge clk) disable iff (rst)
    (ext_rst_i || wdt_ovf_i) |=> (mode_o == 3'd0)); // R8

  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd0 && !ext_rst_i && !wdt_ovf_i) |=> (mode_o == 3'd1)); // R1

  AST_RESET_ENABLES: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd0) |-> (!bm_clk_en_o && !per_clk_en_o)); // R1

  AST_HIGH_ENABLES: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd1) |-> (bm_clk_en_o && per_clk_en_o)); // R4

  AST_MEDIUM_PERIPH: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd2) |-> per_clk_en_o); // R3

  AST_MEDIUM_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd2 && bm_clk_en_o) |=> !(mode_o == 3'd2 && bm_clk_en_o)); // R3

  AST_SLEEP_ENABLES: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd3) |-> (!bm_clk_en_o && per_clk_en_o)); // R5

  AST_STBY_ENABLES: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd4) |-> (!bm_clk_en_o && !per_clk_en_o)); // R6

  AST_STBY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd4 && !irq_ext_i && !ext_rst_i && !wdt_ovf_i) |=> (mode_o == 3'd4)); // R6

  AST_NO_MIDCYCLE_CHANGE: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 3'd1 || mode_o == 3'd2) && !bus_end_i && !sleep_i &&
     !ext_rst_i && !wdt_ovf_i) |=> $stable(mode_o)); // R2
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .sleep_i      (sleep_i),
  .bus_end_i    (bus_end_i),
  .irq_ext_i    (irq_ext_i),
  .ext_rst_i    (ext_rst_i),
  .wdt_ovf_i    (wdt_ovf_i),
  .bm_clk_en_o  (bm_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .mode_o       (mode_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] div_sel = 3'd0;
  logic       stby_en = 1'b0, lson = 1'b0, pss = 1'b0;
  logic       sleep_s = 1'b0, bus_end = 1'b0;
  logic       irq_int = 1'b0, irq_ext = 1'b0;
  logic       ext_rst = 1'b0, wdt_ovf = 1'b0;
  logic       bm_en, per_en;
  logic [2:0] mode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  // reference model state
  int e_mode = 0, e_div = 0, e_k = 0;
  bit e_bm = 1'b0, e_per = 1'b0;

  always #2 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rst(rst), .div_sel_i(div_sel), .stby_en_i(stby_en),
    .lson_i(lson), .wdt_pss_i(pss), .sleep_i(sleep_s), .bus_end_i(bus_end),
    .irq_int_i(irq_int), .irq_ext_i(irq_ext), .ext_rst_i(ext_rst),
    .wdt_ovf_i(wdt_ovf), .bm_clk_en_o(bm_en), .per_clk_en_o(per_en),
    .mode_o(mode)
  );

  function automatic string tag_of(int m);
    case (m)
      0: return "R1/R8";
      1: return "R4";
      2: return "R3/R10";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Behavioural reference: the mode rules and a phase count since the last change
  always @(posedge clk) begin
    int pm, pd, sh, n;
    pm = e_mode; pd = e_div;
    if (rst || ext_rst || wdt_ovf) begin
      e_mode = 0; e_div = 0;
    end else if (pm == 0) begin
      e_mode = 1; e_div = 0;
    end else if (pm == 1 || pm == 2) begin
      if (sleep_s && !lson && !stby_en) e_mode = 3;
      else if (sleep_s && !lson && stby_en && !pss) e_mode = 4;
      else if (bus_end) begin
        e_div = int'(div_sel);
        e_mode = (e_div != 0) ? 2 : 1;
      end
    end else if (pm == 3) begin
      if (irq_int || irq_ext) e_mode = (e_div != 0) ? 2 : 1;
    end else begin
      if (irq_ext) e_mode = (e_div != 0) ? 2 : 1;
    end
    if (e_mode != pm || e_div != pd) e_k = 1; else e_k = e_k + 1;
    sh = (e_div > 5) ? 5 : e_div;
    n = 1 << sh;
    e_bm  = (e_mode == 1) || (e_mode == 2 && (e_k % n) == 0);
    e_per = (e_mode >= 1 && e_mode <= 3);
    started = 1'b1;
    cycles++;
  end

  // Every-clock comparison
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (int'(mode) != e_mode || bm_en != e_bm || per_en != e_per) begin
        errors++;
        $display("FAIL %s cycle %0d: mode/bm/per actual %0d/%0b/%0b expected %0d/%0b/%0b",
                 tag_of(e_mode), cycles, mode, bm_en, per_en, e_mode, e_bm, e_per);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_bus_end(logic [2:0] v);
    div_sel = v; bus_end = 1'b1; step(); bus_end = 1'b0;
  endtask

  task automatic do_sleep();
    sleep_s = 1'b1; step(); sleep_s = 1'b0;
  endtask

  initial begin
    int cnt;
    step(); step();
    chk(mode == 3'd0 && !bm_en && !per_en, "R1 reset state", int'(mode), 0);
    rst = 1'b0; step();
    chk(mode == 3'd1, "R1 leaves reset in high", int'(mode), 1);
    chk(bm_en && per_en, "R4 high enables", int'({bm_en, per_en}), 3);

    // R2: select change without a bus-cycle end
    div_sel = 3'd2;
    for (int i = 0; i < 6; i++) step();
    chk(mode == 3'd1 && bm_en, "R2 select ignored mid-cycle", int'(mode), 1);

    // R3 divide by 4
    pulse_bus_end(3'd2);
    chk(mode == 3'd2, "R3 enters medium", int'(mode), 2);
    cnt = 0;
    for (int i = 0; i < 16; i++) begin step(); if (bm_en) cnt++; end
    chk(cnt == 4, "R3 four pulses in 16 clocks at /4", cnt, 4);
    chk(per_en, "R3 peripheral enable stays high", int'(per_en), 1);

    // R10 restart on divider change, 5 -> /32
    step(); // phase now mid-period
    pulse_bus_end(3'd5);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin step(); if (bm_en) cnt++; end
    chk(cnt == 0, "R10 no early pulse after change", cnt, 0);
    step();
    chk(bm_en, "R10 first pulse on clock 32", int'(bm_en), 1);

    // R3 select 7 saturates at 32
    pulse_bus_end(3'd7);
    cnt = 0;
    for (int i = 0; i < 63; i++) begin step(); if (bm_en) cnt++; end
    chk(cnt == 2, "R3 select 7 gives /32", cnt, 2);

    // R4 back to high
    pulse_bus_end(3'd0);
    chk(mode == 3'd1 && bm_en, "R4 select 000 returns to high", int'(mode), 1);

    // R5/R7 sleep then internal wake at /2
    pulse_bus_end(3'd1);
    step(); step();
    do_sleep();
    chk(mode == 3'd3 && !bm_en && per_en, "R5 sleep entered", int'(mode), 3);
    div_sel = 3'd0; bus_end = 1'b1; step(); bus_end = 1'b0;
    chk(mode == 3'd3, "R2 bus end ignored in sleep", int'(mode), 3);
    irq_int = 1'b1; step(); irq_int = 1'b0;
    chk(mode == 3'd2 && !bm_en, "R7 wake to medium", int'(mode), 2);
    step();
    chk(bm_en, "R7 first pulse after full period", int'(bm_en), 1);

    // R9 ignored SLEEP strobes
    lson = 1'b1; do_sleep();
    chk(mode == 3'd2, "R9 SLEEP with low-speed-on", int'(mode), 2);
    lson = 1'b0; stby_en = 1'b1; pss = 1'b1; do_sleep();
    chk(mode == 3'd2, "R9 SLEEP with prescaler-select", int'(mode), 2);

    // R6 standby
    pss = 1'b0; do_sleep();
    chk(mode == 3'd4 && !bm_en && !per_en, "R6 standby entered", int'(mode), 4);
    irq_int = 1'b1; step(); step(); irq_int = 1'b0;
    chk(mode == 3'd4, "R6 internal interrupt ignored", int'(mode), 4);
    irq_ext = 1'b1; step(); irq_ext = 1'b0;
    chk(mode == 3'd2, "R7 external wake to medium", int'(mode), 2);

    // R8 reset overrides bus end and SLEEP
    stby_en = 1'b0;
    ext_rst = 1'b1; div_sel = 3'd3; bus_end = 1'b1; sleep_s = 1'b1; step();
    bus_end = 1'b0; sleep_s = 1'b0;
    chk(mode == 3'd0 && !bm_en && !per_en, "R8 external reset wins", int'(mode), 0);
    step();
    chk(mode == 3'd0, "R1 held in reset", int'(mode), 0);
    ext_rst = 1'b0; step();
    chk(mode == 3'd1, "R1 high after external reset", int'(mode), 1);

    // R7 wake from sleep with divider 0 goes to high
    do_sleep();
    chk(mode == 3'd3, "R5 sleep from high", int'(mode), 3);
    irq_ext = 1'b1; step(); irq_ext = 1'b0;
    chk(mode == 3'd1 && bm_en, "R7 wake to high", int'(mode), 1);

    // R8 watchdog overflow in sleep beats interrupt
    do_sleep();
    wdt_ovf = 1'b1; irq_int = 1'b1; step(); wdt_ovf = 1'b0; irq_int = 1'b0;
    chk(mode == 3'd0, "R8 watchdog overflow in sleep", int'(mode), 0);
    step();
    chk(mode == 3'd1, "R1 high after watchdog reset", int'(mode), 1);

    step(); step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule